// File: doc/BRIEF.md
# Delay-Slot Squash Controller with Instruction-Address History

This block controls the three-instruction latency region that follows a resolved branch. The pipeline always admits three further instructions before a branch can redirect fetch. A 2-bit execute count carried by the branch decides how many of those slots are kept when the branch is taken, and the rest are squashed. The controller walks the three slots one cycle at a time and raises an execute or a flush flag for each one. On the fourth cycle of a taken branch it loads the next program counter with a target formed from operand A plus or minus a 20-bit immediate.

Alongside the slot controller, the block keeps a seven-deep shift register of accepted instruction addresses, so that the pipeline can be restarted after an exception. While the protected-mode level is high, the four oldest entries are frozen and the three newest keep recording. The frozen entries can be read back one per strobe, newest first. The read pointer returns to the newest frozen entry each time protected mode is entered.

The slot controller is a four-state machine. `ST_IDLE` waits for a branch. `ST_SLOT1`, `ST_SLOT2` and `ST_SLOT3` mark the cycles of the first, second and third latency-slot instruction. The transitions are:
- IDLE to SLOT1 on an accepted branch (strobe without exception).
- SLOT1 to SLOT2 and SLOT2 to SLOT3 when no exception is present.
- SLOT1, SLOT2 or SLOT3 to IDLE on an exception.
- SLOT3 to IDLE unconditionally.

Top module: `dsq_branch_ctl`

## Requirements
- R1: After reset, `slot_num` is 0, `slot_exec`, `slot_flush` and `npc_load` are low, every history entry and `rd_data` are zero, and the read pointer selects entry 3 (the newest frozen entry).
- R2: A `br_vld` pulse in the idle state without `exc_strobe` gives `slot_num` values 1, 2 and 3 on the next three cycles, then 0.
- R3: For a taken branch, slot i (1..3) raises `slot_exec` when i <= `br_exe` and `slot_flush` otherwise. In any slot cycle exactly one of the two flags is high, and both are low when `slot_num` is 0.
- R4: For a not-taken branch, all three slots raise `slot_exec` and `npc_load` stays low.
- R5: For a taken branch, `npc_load` is high for exactly one cycle: the `slot_num` = 3 cycle, which is the fourth cycle counting the branch strobe.
- R6: `npc_val` equals operand A plus `br_imm` (or minus it when `br_sub`=1), modulo 2^32. Operand A is 0 when `br_opa_zero`=1 and `br_opa` otherwise, and the immediate is zero-extended from 20 bits. `npc_val` is held from branch acceptance until the next accepted branch.
- R7: `exc_strobe` in a slot cycle forces `slot_flush` high and `npc_load` low in that cycle and returns to idle on the next cycle. A `br_vld` together with `exc_strobe` in idle is not accepted.
- R8: A `br_vld` during a slot sequence is ignored: the sequence, its flags and `npc_val` are unchanged.
- R9: When `fetch_vld`=1 and `prot_mode`=0, `fetch_pc` enters entry 0 and each entry k moves to k+1. Entry k appears on `hist_flat[32*k +: 32]`.
- R10: While `prot_mode`=1, entries 3..6 hold their values, and entries 0..2 still shift on `fetch_vld`.
- R11: `rd_stb` loads `rd_data`, on the next cycle, with the frozen entry under the pointer. The pointer then steps 3, 4, 5, 6 and wraps to 3. Without `rd_stb`, `rd_data` holds.
- R12: A rising `prot_mode` resets the pointer to entry 3, and an `rd_stb` in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_vld | input | 1 | Resolved-branch strobe |
| br_taken | input | 1 | Branch condition true |
| br_exe | input | 2 | Number of latency slots executed if taken |
| br_opa_zero | input | 1 | Operand A replaced by constant 0 |
| br_sub | input | 1 | Subtract immediate instead of add |
| br_opa | input | 32 | Operand A value (PC register) |
| br_imm | input | 20 | Immediate magnitude |
| exc_strobe | input | 1 | Exception detected this cycle |
| prot_mode | input | 1 | Protected-mode level |
| fetch_vld | input | 1 | Instruction accepted into pipeline |
| fetch_pc | input | 32 | Address of accepted instruction |
| rd_stb | input | 1 | History readback strobe |
| slot_num | output | 2 | Current latency slot, 0 when idle |
| slot_exec | output | 1 | Current slot instruction executes |
| slot_flush | output | 1 | Current slot instruction is squashed |
| npc_load | output | 1 | Load next-PC with target |
| npc_val | output | 32 | Branch target |
| hist_flat | output | 224 | All seven history entries, entry 0 lowest |
| rd_data | output | 32 | Readback data |

## Verification
The bound checker watches every cycle for the following:
- the slot numbering order and the return to idle;
- the exclusivity of execute and flush;
- the placement of the next-PC load in the third slot;
- exception squashing;
- the freezing of the locked history entries;
- the hold of readback data without a strobe.

Which slots execute for a given execute count and outcome, the arithmetic of the target, the step-and-wrap order of readback, and the pointer reset on protected-mode entry all depend on values carried in from earlier cycles. These can only be shown by the bench's branch table and its directed history and readback scenarios.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    localparam int SLOT_N = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLOT1 = 2'd1,
        ST_SLOT2 = 2'd2,
        ST_SLOT3 = 2'd3
    } slot_st_e;
endpackage

// File: rtl/dsq_tgt_calc.sv
module dsq_tgt_calc #(
    parameter int AW    = 32,
    parameter int IMM_W = 20
) (
    input  logic             opa_zero,
    input  logic             sub,
    input  logic [AW-1:0]    opa,
    input  logic [IMM_W-1:0] imm,
    output logic [AW-1:0]    tgt
);
    localparam int PAD = AW - IMM_W;

    logic [AW-1:0] a_eff;
    logic [AW-1:0] imm_ext;

    always_comb begin
        a_eff   = opa_zero ? '0 : opa;
        imm_ext = {{PAD{1'b0}}, imm};
        tgt     = sub ? (a_eff - imm_ext) : (a_eff + imm_ext);
    end
endmodule

// File: rtl/dsq_slot_fsm.sv
module dsq_slot_fsm
    import dsq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int EXE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_vld,
    input  logic             br_taken,
    input  logic [EXE_W-1:0] br_exe,
    input  logic [AW-1:0]    tgt_in,
    input  logic             exc,
    output logic [1:0]       slot_num,
    output logic             slot_exec,
    output logic             slot_flush,
    output logic             npc_load,
    output logic [AW-1:0]    npc_val
);
    slot_st_e         state_q, state_d;
    logic             taken_q;
    logic [EXE_W-1:0] exe_q;
    logic [AW-1:0]    tgt_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && br_vld && !exc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // branch attributes captured on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            exe_q   <= '0;
            tgt_q   <= '0;
        end else if (accept) begin
            taken_q <= br_taken;
            exe_q   <= br_exe;
            tgt_q   <= tgt_in;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_SLOT1;
            ST_SLOT1: state_d = exc ? ST_IDLE : ST_SLOT2;
            ST_SLOT2: state_d = exc ? ST_IDLE : ST_SLOT3;
            ST_SLOT3: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        slot_num   = 2'd0;
        slot_exec  = 1'b0;
        slot_flush = 1'b0;
        npc_load   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SLOT1, ST_SLOT2, ST_SLOT3: begin
                slot_num = state_q;
                if (exc)
                    slot_flush = 1'b1;
                else if (!taken_q || (slot_num <= exe_q))
                    slot_exec = 1'b1;
                else
                    slot_flush = 1'b1;
                npc_load = (state_q == ST_SLOT3) && taken_q && !exc;
            end
            default: ;
        endcase
    end

    assign npc_val = tgt_q;
endmodule

// File: rtl/dsq_pc_hist.sv
module dsq_pc_hist #(
    parameter int AW     = 32,
    parameter int DEPTH  = 7,
    parameter int LOCK_N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_vld,
    input  logic [AW-1:0]       fetch_pc,
    input  logic                prot_mode,
    output logic [AW*DEPTH-1:0] hist_flat
);
    localparam int LOCK_BASE = DEPTH - LOCK_N;

    logic [AW-1:0] ent [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        logic frozen;
        if (k >= LOCK_BASE) begin : g_lk
            assign frozen = prot_mode;
        end else begin : g_free
            assign frozen = 1'b0;
        end

        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)                      ent[k] <= '0;
                else if (fetch_vld && !frozen)   ent[k] <= fetch_pc;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n)                      ent[k] <= '0;
                else if (fetch_vld && !frozen)   ent[k] <= ent[k-1];
            end
        end

        assign hist_flat[k*AW +: AW] = ent[k];
    end
endmodule

// File: rtl/dsq_hist_rd.sv
module dsq_hist_rd #(
    parameter int AW     = 32,
    parameter int LOCK_N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW*LOCK_N-1:0] locked,
    input  logic                 prot_mode,
    input  logic                 rd_stb,
    output logic [AW-1:0]        rd_data
);
    localparam int PW = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;
    localparam logic [PW-1:0] PTR_LAST = PW'(LOCK_N - 1);

    logic          pm_q;
    logic [PW-1:0] ptr_q;
    logic          pm_rise;

    assign pm_rise = prot_mode && !pm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_q    <= 1'b0;
            ptr_q   <= '0;
            rd_data <= '0;
        end else begin
            pm_q <= prot_mode;
            if (pm_rise) begin
                ptr_q <= '0;
            end else if (rd_stb) begin
                rd_data <= locked[int'(ptr_q)*AW +: AW];
                ptr_q   <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsq_branch_ctl.sv
module dsq_branch_ctl #(
    parameter int AW     = 32,
    parameter int IMM_W  = 20,
    parameter int EXE_W  = 2,
    parameter int DEPTH  = 7,
    parameter int LOCK_N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                br_vld,
    input  logic                br_taken,
    input  logic [EXE_W-1:0]    br_exe,
    input  logic                br_opa_zero,
    input  logic                br_sub,
    input  logic [AW-1:0]       br_opa,
    input  logic [IMM_W-1:0]    br_imm,
    input  logic                exc_strobe,
    input  logic                prot_mode,
    input  logic                fetch_vld,
    input  logic [AW-1:0]       fetch_pc,
    input  logic                rd_stb,
    output logic [1:0]          slot_num,
    output logic                slot_exec,
    output logic                slot_flush,
    output logic                npc_load,
    output logic [AW-1:0]       npc_val,
    output logic [AW*DEPTH-1:0] hist_flat,
    output logic [AW-1:0]       rd_data
);
    localparam int LOCK_BASE = DEPTH - LOCK_N;

    logic [AW-1:0] tgt;

    dsq_tgt_calc #(.AW(AW), .IMM_W(IMM_W)) u_tgt (
        .opa_zero (br_opa_zero),
        .sub      (br_sub),
        .opa      (br_opa),
        .imm      (br_imm),
        .tgt      (tgt)
    );

    dsq_slot_fsm #(.AW(AW), .EXE_W(EXE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .br_vld     (br_vld),
        .br_taken   (br_taken),
        .br_exe     (br_exe),
        .tgt_in     (tgt),
        .exc        (exc_strobe),
        .slot_num   (slot_num),
        .slot_exec  (slot_exec),
        .slot_flush (slot_flush),
        .npc_load   (npc_load),
        .npc_val    (npc_val)
    );

    dsq_pc_hist #(.AW(AW), .DEPTH(DEPTH), .LOCK_N(LOCK_N)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_vld (fetch_vld),
        .fetch_pc  (fetch_pc),
        .prot_mode (prot_mode),
        .hist_flat (hist_flat)
    );

    dsq_hist_rd #(.AW(AW), .LOCK_N(LOCK_N)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .locked    (hist_flat[AW*DEPTH-1 : AW*LOCK_BASE]),
        .prot_mode (prot_mode),
        .rd_stb    (rd_stb),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/dsq_branch_ctl_chk.sv
module dsq_branch_ctl_chk #(
    parameter int AW     = 32,
    parameter int IMM_W  = 20,
    parameter int EXE_W  = 2,
    parameter int DEPTH  = 7,
    parameter int LOCK_N = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                br_vld,
    input logic                exc_strobe,
    input logic                prot_mode,
    input logic                fetch_vld,
    input logic [AW-1:0]       fetch_pc,
    input logic                rd_stb,
    input logic [1:0]          slot_num,
    input logic                slot_exec,
    input logic                slot_flush,
    input logic                npc_load,
    input logic [AW-1:0]       npc_val,
    input logic [AW*DEPTH-1:0] hist_flat,
    input logic [AW-1:0]       rd_data
);
    localparam int LOCK_LO = AW * (DEPTH - LOCK_N);

    a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_num == 2'd0 && br_vld && !exc_strobe) |=> slot_num == 2'd1);

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_num != 2'd0 && slot_num != 2'd3 && !exc_strobe) |=> slot_num == $past(slot_num) + 2'd1);

    a_r2_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_num == 2'd3) |=> slot_num == 2'd0);

    a_r3_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_num != 2'd0) |-> (slot_exec ^ slot_flush));

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_num == 2'd0) |-> (!slot_exec && !slot_flush && !npc_load));

    a_r5_load_in_slot3: assert property (@(posedge clk) disable iff (!rst_n)
        npc_load |-> (slot_num == 2'd3 && !exc_strobe));

    a_r7_exc_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_strobe && slot_num != 2'd0) |-> (slot_flush && !npc_load));

    a_r7_exc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        exc_strobe |=> slot_num == 2'd0);

    a_r8_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_num != 2'd0) |=> $stable(npc_val));

    a_r9_newest: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && !prot_mode) |=> hist_flat[AW-1:0] == $past(fetch_pc));

    a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
        prot_mode |=> $stable(hist_flat[AW*DEPTH-1:LOCK_LO]));

    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
endmodule

bind dsq_branch_ctl dsq_branch_ctl_chk #(
    .AW(AW), .IMM_W(IMM_W), .EXE_W(EXE_W), .DEPTH(DEPTH), .LOCK_N(LOCK_N)
) u_chk (.*);

// File: tb/dsq_branch_ctl_tb_top.sv
module dsq_branch_ctl_tb_top;
    localparam int CLK_P = 10;
    localparam int NV    = 8;
    // {taken, exe[1:0], opa_zero, sub, opa[31:0], imm[19:0]}
    localparam logic [56:0] VEC [NV] = '{
        {1'b1, 2'd0, 1'b0, 1'b0, 32'h1000_0000, 20'h00400},
        {1'b1, 2'd1, 1'b0, 1'b1, 32'h0000_2000, 20'h00010},
        {1'b1, 2'd2, 1'b1, 1'b0, 32'hDEAD_BEEF, 20'hFFFFF},
        {1'b1, 2'd3, 1'b0, 1'b0, 32'hFFFF_FFF0, 20'h00020},
        {1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0100, 20'h00001},
        {1'b0, 2'd2, 1'b1, 1'b1, 32'h0000_0040, 20'h00008},
        {1'b1, 2'd1, 1'b1, 1'b1, 32'h0000_0005, 20'h00001},
        {1'b1, 2'd2, 1'b0, 1'b1, 32'h8000_0000, 20'h80000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic br_vld = 0, br_taken = 0, br_opa_zero = 0, br_sub = 0;
    logic [1:0] br_exe = 0;
    logic [31:0] br_opa = 0;
    logic [19:0] br_imm = 0;
    logic exc_strobe = 0, prot_mode = 0, fetch_vld = 0, rd_stb = 0;
    logic [31:0] fetch_pc = 0;
    logic [1:0] slot_num;
    logic slot_exec, slot_flush, npc_load;
    logic [31:0] npc_val, rd_data;
    logic [223:0] hist_flat;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_h [7];

    always #(CLK_P/2) clk = ~clk;

    dsq_branch_ctl dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tgt_of(input logic oz, input logic sb,
                                           input logic [31:0] a, input logic [19:0] im);
        logic [31:0] ae;
        ae = oz ? 32'd0 : a;
        return sb ? ae - {12'd0, im} : ae + {12'd0, im};
    endfunction

    // exc_at: 0 = none, 1..3 = slot cycle that sees the exception
    task automatic run_branch(input logic tk, input logic [1:0] ex, input logic oz,
                              input logic sb, input logic [31:0] a, input logic [19:0] im,
                              input int exc_at);
        logic [31:0] t;
        t = tgt_of(oz, sb, a, im);
        @(negedge clk);
        br_vld = 1; br_taken = tk; br_exe = ex; br_opa_zero = oz; br_sub = sb;
        br_opa = a; br_imm = im;
        @(negedge clk);
        br_vld = 0;
        for (int s = 1; s <= 3; s++) begin
            exc_strobe = (s == exc_at);
            #1;
            if (exc_at != 0 && s > exc_at) begin
                chk("R7 idle after exception", 32'(slot_num), 32'd0);
            end else begin
                logic ex_exp;
                ex_exp = (s != exc_at) && (!tk || s <= int'(ex));
                chk("R2 slot number", 32'(slot_num), 32'(s));
                chk(tk ? "R3 exec flag" : "R4 exec flag", 32'(slot_exec), 32'(ex_exp));
                chk(s == exc_at ? "R7 flush flag" : "R3 flush flag", 32'(slot_flush), 32'(!ex_exp));
                chk("R5 npc_load", 32'(npc_load), 32'(tk && s == 3 && s != exc_at));
                if (s == 3 && tk && exc_at == 0) chk("R6 target", npc_val, t);
            end
            @(negedge clk);
            exc_strobe = 0;
        end
        #1;
        chk("R2 back to idle", 32'(slot_num), 32'd0);
        chk("R4 no load when idle", 32'(npc_load), 32'd0);
    endtask

    task automatic fetch(input logic [31:0] pc);
        @(negedge clk);
        fetch_vld = 1; fetch_pc = pc;
        @(negedge clk);
        fetch_vld = 0;
        for (int k = 6; k >= 1; k--)
            if (!(prot_mode && k >= 3)) exp_h[k] = exp_h[k-1];
        exp_h[0] = pc;
    endtask

    task automatic chk_hist(input string tag);
        for (int k = 0; k < 7; k++) chk(tag, hist_flat[k*32 +: 32], exp_h[k]);
    endtask

    task automatic rd_one(input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_stb = 1;
        @(negedge clk);
        rd_stb = 0;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 7; k++) exp_h[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 slot_num", 32'(slot_num), 0);
        chk("R1 flags", {29'd0, slot_exec, slot_flush, npc_load}, 0);
        chk("R1 rd_data", rd_data, 0);
        chk_hist("R1 history zero");

        // table of branch vectors
        for (int i = 0; i < NV; i++)
            run_branch(VEC[i][56], VEC[i][55:54], VEC[i][53], VEC[i][52],
                       VEC[i][51:20], VEC[i][19:0], 0);

        // R7 exceptions in each slot
        run_branch(1'b1, 2'd3, 1'b0, 1'b0, 32'h100, 20'h10, 1);
        run_branch(1'b1, 2'd0, 1'b0, 1'b0, 32'h200, 20'h10, 2);
        run_branch(1'b1, 2'd3, 1'b0, 1'b0, 32'h300, 20'h10, 3);

        // R7 branch with exception in idle is not accepted
        @(negedge clk);
        br_vld = 1; exc_strobe = 1; br_taken = 1;
        @(negedge clk);
        br_vld = 0; exc_strobe = 0;
        #1 chk("R7 branch with exception dropped", 32'(slot_num), 0);

        // R8 branch during sequence ignored
        @(negedge clk);
        br_vld = 1; br_taken = 1; br_exe = 0; br_opa_zero = 0; br_sub = 0;
        br_opa = 32'h4000; br_imm = 20'h4;
        @(negedge clk);
        br_taken = 0; br_opa = 32'h9999; br_exe = 3;          // br_vld still high in SLOT1
        @(negedge clk);
        br_vld = 0;
        #1 chk("R8 still in sequence", 32'(slot_num), 2);
        chk("R8 flush kept", 32'(slot_flush), 1);
        @(negedge clk);
        #1 chk("R8 load kept", 32'(npc_load), 1);
        chk("R8 target kept", npc_val, 32'h4004);
        @(negedge clk);
        #1 chk("R8 no new sequence", 32'(slot_num), 0);

        // R9 history shifting
        for (int i = 0; i < 7; i++) fetch(32'hA000_0000 + 32'(i * 4));
        chk_hist("R9 history shift");
        // R11 first read after reset starts at entry 3 (R1 pointer)
        rd_one(exp_h[3], "R1 pointer at entry 3");

        // R10 protected-mode lock
        @(negedge clk);
        prot_mode = 1;
        @(negedge clk);
        fetch(32'hB000_0000);
        fetch(32'hB000_0004);
        chk_hist("R10 locked entries hold");

        // R11 readback order and wrap (pointer reset on entry, R12)
        rd_one(exp_h[3], "R11 read entry 3");
        rd_one(exp_h[4], "R11 read entry 4");
        rd_one(exp_h[5], "R11 read entry 5");
        rd_one(exp_h[6], "R11 read entry 6");
        rd_one(exp_h[3], "R11 read wraps");
        @(negedge clk);
        #1 chk("R11 rd_data holds", rd_data, exp_h[3]);

        // R12 re-entry with simultaneous strobe
        prot_mode = 0;
        @(negedge clk);
        prot_mode = 1; rd_stb = 1;
        @(negedge clk);
        rd_stb = 0;
        chk("R12 strobe on entry ignored", rd_data, exp_h[3]);
        rd_one(exp_h[3], "R12 pointer reset to entry 3");
        rd_one(exp_h[4], "R12 pointer steps after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule